// File: doc/BRIEF.md
# Successive-Approximation ADC Conversion Controller

This block sequences single conversions of a successive-approximation converter that serves three analog inputs. Software programs the timing through a 32-bit register bus. It then starts a conversion by writing an enable bit together with a one-hot channel choice. The block runs a startup phase, a sample-window phase and a compare phase. Each phase lasts a programmable number of ticks of a conversion clock, which is the bus clock divided by a programmable ratio.

During the compare phase the block presents a trial code to the external converter array. It takes one comparator decision per tick, starting at the most significant bit. The finished code is stored in the result register of the converted channel, where a valid flag marks it as fresh. A completion flag is also raised, which software can clear and which can drive an interrupt line. Writing zero to the control register stops a running conversion, so that software can always begin from a known state.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset, busy (offset 0x08 bit 0) is low, the cycle-configuration register (0x0C) reads zero, every result register and the pending flag read zero, and the interrupt output is low.
- R2: A write to the control register (0x04) with bit 0 set and exactly one of bits 7:5 set (bit 5+n selects channel n) starts a conversion, and busy reads 1 from the next cycle. The control register reads back bit 0 and bits 7:5 as written.
- R3: The cycle-configuration register keeps the startup count in bits 4:0, the sample count in bits 11:8, the divider in bits 15:12 and the compare count in bits 19:16, and reads these back with all other bits zero.
- R4: With field values S, W, D and C, busy stays high for exactly (D+1)*((S+1)+(W+1)+(C+1)) clock cycles after the starting write.
- R5: The compare phase takes min(C+1, 12) comparator decisions, MSB first, one per conversion tick. The trial-code output shows the bits decided so far plus the bit under test. Bits left undecided are stored as zero.
- R6: Channel n's result sits at 0x14+4n, with the code in bits 11:0 and valid in bit 15. Valid clears when a conversion on that channel starts and sets when its result is stored. The other channels' result registers are unchanged.
- R7: A control write with bit 0 clear stops a running conversion. Busy is low from the next cycle, and no result and no pending flag are produced. A start written while busy restarts the conversion on the newly chosen channel.
- R8: The pending flag (0x28 bit 0) sets when a conversion completes. Writing 1 to bit 0 of 0x24 clears it, and completion wins over a clear in the same cycle. The interrupt output is pending AND enable (0x20 bit 0).
- R9: Unmapped offsets and unused bits read zero, and writes to them or to read-only registers have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and converter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| cmp_in | input | 1 | Comparator decision: 1 when the input is at or above the trial code |
| trial_code | output | 12 | Code presented to the converter array |
| irq | output | 1 | Completion interrupt |

## Verification
The bench builds the block with its default parameters: three channels, 12-bit results, a 4-bit divider and 4-bit sample and compare counts, with a 5-bit startup count. These defaults allow compare counts both below and above twelve, so truncated and full conversions both occur. Divider ratios from 1 to 16 are used, and every channel is used, so that the result flags of idle channels can be checked. The comparator is modelled as a compare of a random input code against the trial code. The expected result is that input code with its undecided low bits masked off.

// File: rtl/sar_pkg.sv
package sar_pkg;
  // Register byte offsets
  localparam int OFF_CTRL  = 'h04;
  localparam int OFF_STAT  = 'h08;
  localparam int OFF_CFG   = 'h0C;
  localparam int OFF_RES0  = 'h14;
  localparam int OFF_IEN   = 'h20;
  localparam int OFF_ICLR  = 'h24;
  localparam int OFF_IPEND = 'h28;

  // Bit positions the sequencer and software agree on
  localparam int SEL_LSB   = 5;
  localparam int VALID_BIT = 15;
  localparam int SU_LSB    = 0;
  localparam int SW_LSB    = 8;
  localparam int DIV_LSB   = 12;
  localparam int CP_LSB    = 16;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_STARTUP = 2'd1,
    PH_SAMPLE  = 2'd2,
    PH_COMPARE = 2'd3
  } phase_e;
endpackage

// File: rtl/sar_tick_div.sv
module sar_tick_div #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign tick   = run && (cnt_q == div);
  assign cnt_en = clear || run;

  always_comb begin
    cnt_d = cnt_q;
    if (clear || tick) cnt_d = '0;
    else               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R4: ticks are spaced div+1 cycles apart; the counter never passes the divider
  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= div) || $changed(div));
endmodule

// File: rtl/sar_engine.sv
module sar_engine
  import sar_pkg::*;
#(
  parameter int RES_W = 12,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic             tick,
  input  logic             cmp_in,
  input  logic [CNT_W-1:0] lim_startup,
  input  logic [CNT_W-1:0] lim_sample,
  input  logic [CNT_W-1:0] lim_compare,
  output logic             busy,
  output logic             done,
  output logic [RES_W-1:0] res_next,
  output logic [RES_W-1:0] trial
);
  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] pcnt_q, pcnt_d, lim;
  logic [RES_W-1:0] acc_q, acc_d, probe;
  logic             upd, last, in_sar;

  assign busy   = (phase_q != PH_IDLE);
  assign upd    = start || abort || (tick && busy);
  assign in_sar = (phase_q == PH_COMPARE) && (int'(pcnt_q) < RES_W);

  always_comb begin
    probe = '0;
    for (int k = 0; k < RES_W; k++)
      if (in_sar && (int'(pcnt_q) == RES_W - 1 - k)) probe[k] = 1'b1;
  end

  assign trial = acc_q | probe;

  always_comb begin
    case (phase_q)
      PH_STARTUP: lim = lim_startup;
      PH_SAMPLE:  lim = lim_sample;
      default:    lim = lim_compare;
    endcase
  end
  assign last = (pcnt_q == lim);

  always_comb begin
    phase_d = phase_q;
    pcnt_d  = pcnt_q;
    acc_d   = acc_q;
    done    = 1'b0;
    if (abort) begin
      phase_d = PH_IDLE;
      pcnt_d  = '0;
    end else if (start) begin
      phase_d = PH_STARTUP;
      pcnt_d  = '0;
      acc_d   = '0;
    end else if (tick && busy) begin
      pcnt_d = last ? '0 : pcnt_q + 1'b1;
      if (phase_q == PH_COMPARE && cmp_in) acc_d = acc_q | probe;
      if (last) begin
        case (phase_q)
          PH_STARTUP: phase_d = PH_SAMPLE;
          PH_SAMPLE:  phase_d = PH_COMPARE;
          default: begin
            phase_d = PH_IDLE;
            done    = 1'b1;
          end
        endcase
      end
    end
  end

  assign res_next = acc_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      pcnt_q  <= '0;
      acc_q   <= '0;
    end else if (upd) begin
      phase_q <= phase_d;
      pcnt_q  <= pcnt_d;
      acc_q   <= acc_d;
    end
  end

  a_r2_start_enters_startup: assert property (@(posedge clk) disable iff (!rst_n)
    start && !abort |=> phase_q == PH_STARTUP);
  a_r7_abort_idles: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !busy);
  a_r4_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  a_r4_phase_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !start && !abort |=> $stable(phase_q));
  a_r5_one_probe_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(probe));
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
  import sar_pkg::*;
#(
  parameter int NCH    = 3,
  parameter int RES_W  = 12,
  parameter int ADDR_W = 8,
  parameter int DW     = 32,
  parameter int SU_W   = 5,
  parameter int SW_W   = 4,
  parameter int DIV_W  = 4,
  parameter int CP_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              cmp_in,
  output logic [RES_W-1:0]  trial_code,
  output logic              irq
);
  localparam int CNT_W = (SU_W > CP_W) ? SU_W : CP_W;
  localparam logic [DW-1:0] CTRL_MASK = DW'(((1 << NCH) - 1) << SEL_LSB) | DW'(1);
  localparam logic [DW-1:0] CFG_MASK  = DW'(((1 << SU_W) - 1) << SU_LSB)
                                      | DW'(((1 << SW_W) - 1) << SW_LSB)
                                      | DW'(((1 << DIV_W) - 1) << DIV_LSB)
                                      | DW'(((1 << CP_W) - 1) << CP_LSB);

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rsync_q;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s_n = rsync_q[1];

  // Bus decode
  logic            wr_ctrl, wr_cfg, wr_ien, wr_iclr;
  logic            start, abort, done, busy, tick;
  logic [NCH-1:0]  sel_w;
  logic [DW-1:0]   ctrl_q, cfg_q, ien_q;
  logic            pend_q, pend_d;
  logic [NCH-1:0]  ch_q;
  logic [RES_W-1:0] res_next;

  assign wr_ctrl = bus_we && (bus_addr == ADDR_W'(OFF_CTRL));
  assign wr_cfg  = bus_we && (bus_addr == ADDR_W'(OFF_CFG));
  assign wr_ien  = bus_we && (bus_addr == ADDR_W'(OFF_IEN));
  assign wr_iclr = bus_we && (bus_addr == ADDR_W'(OFF_ICLR)) && bus_wdata[0];
  assign sel_w   = bus_wdata[SEL_LSB +: NCH];
  assign start   = wr_ctrl && bus_wdata[0] && $onehot(sel_w);
  assign abort   = wr_ctrl && !bus_wdata[0];

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      ctrl_q <= '0;
      cfg_q  <= '0;
      ien_q  <= '0;
      ch_q   <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= bus_wdata & CTRL_MASK;
      if (wr_cfg)  cfg_q  <= bus_wdata & CFG_MASK;
      if (wr_ien)  ien_q  <= bus_wdata & DW'(1);
      if (start)   ch_q   <= sel_w;
    end
  end

  // Completion flag: a finishing conversion wins over a clear
  always_comb begin
    pend_d = pend_q;
    if (wr_iclr) pend_d = 1'b0;
    if (done)    pend_d = 1'b1;
  end
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) pend_q <= 1'b0;
    else          pend_q <= pend_d;
  end
  assign irq = pend_q && ien_q[0];

  sar_tick_div #(.DIV_W(DIV_W)) u_div (
    .clk   (clk),
    .rst_n (rst_s_n),
    .clear (start || abort),
    .run   (busy),
    .div   (cfg_q[DIV_LSB +: DIV_W]),
    .tick  (tick)
  );

  sar_engine #(.RES_W(RES_W), .CNT_W(CNT_W)) u_eng (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .start       (start),
    .abort       (abort),
    .tick        (tick),
    .cmp_in      (cmp_in),
    .lim_startup (CNT_W'(cfg_q[SU_LSB +: SU_W])),
    .lim_sample  (CNT_W'(cfg_q[SW_LSB +: SW_W])),
    .lim_compare (CNT_W'(cfg_q[CP_LSB +: CP_W])),
    .busy        (busy),
    .done        (done),
    .res_next    (res_next),
    .trial       (trial_code)
  );

  // Per-channel result registers
  logic [RES_W-1:0] res_q [NCH];
  logic [NCH-1:0]   valid_q;
  for (genvar n = 0; n < NCH; n++) begin : g_ch
    logic res_we, vld_clr;
    assign res_we  = done && ch_q[n];
    assign vld_clr = start && sel_w[n];
    always_ff @(posedge clk or negedge rst_s_n) begin
      if (!rst_s_n) begin
        res_q[n]   <= '0;
        valid_q[n] <= 1'b0;
      end else if (res_we || vld_clr) begin
        if (res_we) res_q[n] <= res_next;
        valid_q[n] <= res_we && !vld_clr;
      end
    end
  end

  // Read mux
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(OFF_CTRL):  bus_rdata = ctrl_q;
      ADDR_W'(OFF_STAT):  bus_rdata[0] = busy;
      ADDR_W'(OFF_CFG):   bus_rdata = cfg_q;
      ADDR_W'(OFF_IEN):   bus_rdata = ien_q;
      ADDR_W'(OFF_IPEND): bus_rdata[0] = pend_q;
      default: ;
    endcase
    for (int n = 0; n < NCH; n++) begin
      if (bus_addr == ADDR_W'(OFF_RES0 + 4 * n)) begin
        bus_rdata[RES_W-1:0] = res_q[n];
        bus_rdata[VALID_BIT] = valid_q[n];
      end
    end
  end

  a_r8_done_sets_pending: assert property (@(posedge clk) disable iff (!rst_s_n)
    done |=> pend_q);
  a_r6_done_sets_valid: assert property (@(posedge clk) disable iff (!rst_s_n)
    done |=> (valid_q & ch_q) == ch_q);
  a_r6_start_clears_valid: assert property (@(posedge clk) disable iff (!rst_s_n)
    start |=> (valid_q & ch_q) == '0);
  a_r7_abort_no_pending: assert property (@(posedge clk) disable iff (!rst_s_n)
    abort && !pend_q |=> !pend_q);
  a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_s_n)
    irq |-> ien_q[0] && pend_q);
endmodule

// File: tb/sar_adc_ctrl_tb_top.sv
module sar_adc_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [11:0] trial_code;
  logic [11:0] vin = '0;
  logic        cmp_in;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done_run = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;
  assign cmp_in = (vin >= trial_code);

  sar_adc_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmp_in(cmp_in),
    .trial_code(trial_code), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  function automatic int conv_len(input logic [31:0] cfg);
    return (int'(cfg[15:12]) + 1) *
           ((int'(cfg[4:0]) + 1) + (int'(cfg[11:8]) + 1) + (int'(cfg[19:16]) + 1));
  endfunction

  function automatic logic [11:0] exp_code(input logic [11:0] v, input logic [31:0] cfg);
    int d = int'(cfg[19:16]) + 1;
    logic [11:0] m = (d >= 12) ? 12'hFFF : (12'hFFF << (12 - d));
    return v & m;
  endfunction

  // Starts a conversion and returns the number of busy cycles seen
  task automatic convert(input int ch, output int n);
    logic [31:0] s;
    wr(8'h04, 32'h0);
    wr(8'h04, 32'h1 | (32'h1 << (5 + ch)));
    n = 0;
    rd(8'h08, s);
    while (s[0] && n < 5000) begin
      n++;
      @(negedge clk);
      rd(8'h08, s);
    end
  endtask

  initial begin
    repeat (20000 * 10) @(posedge clk);
    if (!done_run) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, cfg;
    logic [31:0] vsnap [3];
    int n;
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(8'h08, r); check("R1 busy", r, 0);
    rd(8'h0C, r); check("R1 cfg", r, 0);
    for (int c = 0; c < 3; c++) begin rd(8'(8'h14 + 4 * c), r); check("R1 result", r, 0); end
    rd(8'h28, r); check("R1 pending", r, 0);
    check("R1 irq", {31'b0, irq}, 0);

    // R3 and R9 register fields, unused bits
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h0C, r); check("R3 cfg mask", r, 32'h000F_FF1F);
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, r); check("R9 unmapped", r, 0);
    rd(8'h3C, r); check("R9 unmapped high", r, 0);
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, r); check("R9 status read-only", r, 0);

    // R2 invalid select does not start; readback
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h08, r); check("R2 two-hot no start", r, 0);
    rd(8'h04, r); check("R2 ctrl readback", r, 32'h0000_00E1);

    // R4/R5/R6/R8 directed: full resolution, fastest divider
    cfg = 32'h000F_0000;
    wr(8'h0C, cfg);
    wr(8'h20, 32'h1);
    vin = 12'hA5C;
    convert(1, n);
    check("R4 busy length", n, conv_len(cfg));
    rd(8'h18, r); check("R5 R6 result ch1", r, 32'h8000 | exp_code(vin, cfg));
    rd(8'h14, r); check("R6 ch0 untouched", r, 0);
    rd(8'h28, r); check("R8 pending", r, 1);
    check("R8 irq asserted", {31'b0, irq}, 1);
    wr(8'h24, 32'h1);
    rd(8'h28, r); check("R8 cleared", r, 0);
    check("R8 irq low", {31'b0, irq}, 0);
    wr(8'h18, 32'h0);
    rd(8'h18, r); check("R9 result read-only", r, 32'h8000 | exp_code(vin, cfg));

    // R5 truncated compare: 3 decisions
    cfg = 32'h0002_1203;
    wr(8'h0C, cfg);
    vin = 12'hFFF;
    convert(2, n);
    check("R4 truncated length", n, conv_len(cfg));
    rd(8'h1C, r); check("R5 truncated result", r, 32'h8000 | 32'hE00);
    wr(8'h24, 32'h1);

    // R7 abort: valid cleared by start, no result, no pending
    cfg = 32'h000F_3F1F;
    wr(8'h0C, cfg);
    wr(8'h04, 32'h0);
    wr(8'h04, 32'h1 | (32'h1 << 6));
    repeat (20) @(negedge clk);
    rd(8'h18, r); check("R6 valid cleared on start", r[15], 0);
    wr(8'h04, 32'h0);
    rd(8'h08, r); check("R7 abort busy low", r, 0);
    repeat (5) @(negedge clk);
    rd(8'h28, r); check("R7 abort no pending", r, 0);
    rd(8'h18, r); check("R7 abort no valid", r[15], 0);

    // R7 restart while busy on another channel
    cfg = 32'h0003_0101;
    wr(8'h0C, cfg);
    vin = 12'h3C3;
    wr(8'h04, 32'h1 | (32'h1 << 5));
    repeat (3) @(negedge clk);
    wr(8'h04, 32'h1 | (32'h1 << 7));
    n = 0;
    rd(8'h08, r);
    while (r[0] && n < 5000) begin n++; @(negedge clk); rd(8'h08, r); end
    check("R7 restart length", n, conv_len(cfg));
    rd(8'h1C, r); check("R7 restart channel", r, 32'h8000 | exp_code(vin, cfg));
    wr(8'h24, 32'h1);

    // Random conversions
    wr(8'h20, 32'h0);
    for (int c = 0; c < 3; c++) begin rd(8'(8'h14 + 4 * c), r); vsnap[c] = r; end
    for (int i = 0; i < 24; i++) begin
      int ch = $urandom_range(0, 2);
      cfg = {12'b0, 4'($urandom), 4'($urandom), 4'($urandom), 3'b0, 5'($urandom)};
      vin = 12'($urandom);
      wr(8'h0C, cfg);
      convert(ch, n);
      check("R4 random length", n, conv_len(cfg));
      rd(8'(8'h14 + 4 * ch), r);
      check("R5 R6 random result", r, 32'h8000 | exp_code(vin, cfg));
      vsnap[ch] = r;
      for (int c = 0; c < 3; c++) begin
        rd(8'(8'h14 + 4 * c), r);
        check("R6 other channels kept", r, vsnap[c]);
      end
      rd(8'h28, r); check("R8 pending random", r, 1);
      check("R8 irq masked", {31'b0, irq}, 0);
      wr(8'h24, 32'h1);
    end

    done_run = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule